// File: doc/BRIEF.md
# Unified Rename-Reorder Instruction Shelf

This block holds every instruction in flight in one circular array. Each slot acts as a reorder-buffer slot, a rename-table entry and a reservation station at the same time. An instruction's tag is the index of the slot it occupies. New instructions take the slot at the allocation end, and results commit from the oldest end in program order.

At issue, each of the two source registers is looked up by associative match against the destination field of every active slot. Only the slot that is the newest writer of that register can match, and a "newest-writer" bit marks that slot. A matching source records the producer's tag, and it is locked while that producer has not executed. An update from a functional unit writes the result into its slot, marks the slot executed and unlocks every waiting source that names the tag. The oldest slot commits once it has executed, and its register write goes out to an external architectural register file.

A flush names a faulting or mispredicted instruction. It discards every slot younger than that instruction and rebuilds the newest-writer bits of the slots that remain. Issue, update, dispatch and commit can each occur once per cycle.

Top module: `rrs_shelf`

## Requirements
- R1: While reset is held and after it is released, `empty` is 1, `full` is 0, `ret_valid` is 0 and `ready_vec` is all zeros.
- R2: An accepted issue gets the tag shown on `iss_tag`, which is the current allocation slot. Tags advance by one per accepted issue and wrap modulo N.
- R3: In the issue cycle, a source reports `hit`=1 and the producer's slot index on its `id` output when an active slot has that register as its destination with its newest-writer bit set. With no such slot, the source reports `hit`=0 and `lock`=0.
- R4: A renamed source reports `lock`=1 when its producer has not yet executed.
- R5: Each accepted issue makes its own slot the only newest writer of its destination register, so a later lookup of that register returns the newest slot.
- R6: An update (`upd_valid`, `upd_tag`, `upd_data`) marks the slot executed and clears the lock of every source waiting on that tag. Bit i of `ready_vec` is 1 exactly when slot i is active, both of its sources are unlocked, and it is neither dispatched nor executed.
- R7: `disp_tag` selects a slot whose stored PC, source registers and producer tags appear on the `disp_*` outputs. A cycle with `disp_valid`=1 marks that slot dispatched and clears its `ready_vec` bit.
- R8: Only the oldest slot commits, and only once it has executed. `ret_valid`, `ret_dst`, `ret_data` and `ret_pc` show it, and it is freed at the next edge, so commits follow program order even when results arrive out of order.
- R9: Once a slot has committed, or in the very cycle it commits, a lookup of its destination register no longer matches it and reports `hit`=0.
- R10: When an update and an issue occur in the same cycle and a new source's producer is the updating tag, that source is recorded and reported as unlocked.
- R11: A flush (`flush_valid`, `flush_tag`) discards every slot younger than `flush_tag` and keeps that slot. The next tag becomes `flush_tag`+1, and the newest-writer bits of the remaining slots are rebuilt. Issue and commit are held off in the flush cycle.
- R12: `full` is 1 when all N slots are active, and an issue presented while full is ignored. `empty` is 1 when no slot is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_dst | input | RW | Destination register of the issuing instruction |
| iss_src1 | input | RW | First source register |
| iss_src2 | input | RW | Second source register |
| iss_fu | input | 2 | Functional-unit class |
| iss_pc | input | PW | Instruction address |
| iss_tag | output | IW | Slot assigned to the issuing instruction |
| iss_s1_hit | output | 1 | First source renamed to an in-flight producer |
| iss_s1_id | output | IW | Producer tag for the first source |
| iss_s1_lock | output | 1 | First source waits for its producer |
| iss_s2_hit | output | 1 | Second source renamed to an in-flight producer |
| iss_s2_id | output | IW | Producer tag for the second source |
| iss_s2_lock | output | 1 | Second source waits for its producer |
| upd_valid | input | 1 | Result returning from a functional unit |
| upd_tag | input | IW | Slot of the returning result |
| upd_data | input | DW | Result value |
| disp_valid | input | 1 | Mark the selected slot dispatched |
| disp_tag | input | IW | Slot read out for dispatch |
| disp_fu | output | 2 | Functional-unit class of the selected slot |
| disp_pc | output | PW | Instruction address of the selected slot |
| disp_s1_reg | output | RW | First source register of the selected slot |
| disp_s1_id | output | IW | First source producer tag |
| disp_s1_hit | output | 1 | First source was renamed |
| disp_s2_reg | output | RW | Second source register of the selected slot |
| disp_s2_id | output | IW | Second source producer tag |
| disp_s2_hit | output | 1 | Second source was renamed |
| ready_vec | output | N | Per-slot ready-to-dispatch flags |
| ret_valid | output | 1 | Oldest slot commits this cycle |
| ret_dst | output | RW | Architectural register written by the commit |
| ret_data | output | DW | Value written by the commit |
| ret_pc | output | PW | Address of the committing instruction |
| flush_valid | input | 1 | Discard all slots younger than flush_tag |
| flush_tag | input | IW | Slot of the faulting instruction |
| full | output | 1 | All slots active |
| empty | output | 1 | No slot active |

## Verification
The rename results on `iss_tag`, `iss_s*_*` and `disp_*` are combinational, so the bench reads them 1 ns after driving the inputs, within the same cycle. `ready_vec`, `full`, `empty` and the commit outputs come from registered state, so they change one edge after the issue, update, dispatch or flush that caused them, and the bench checks them at the following falling edge. A commit becomes visible one edge after its update and frees its slot at the next edge. The monitor therefore pops one expected commit at each falling edge where `ret_valid` is high, which counts every commit exactly once.

// File: rtl/rrs_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the rename-reorder shelf.
// Assumes a fixed two-bit functional-unit class field.
package rrs_pkg;
    localparam int FU_W = 2;
    typedef enum logic [FU_W-1:0] {
        FU_INT = 2'd0,
        FU_MUL = 2'd1,
        FU_MEM = 2'd2,
        FU_BRN = 2'd3
    } fu_kind_e;
endpackage

// File: rtl/rrs_ptr_ctrl.sv
`timescale 1ns/1ps
// Allocation and commit pointers with an occupancy count.
// Assumes N is a power of two, so the pointers wrap naturally.
// A flush cuts the queue back to just after flush_tag.
// Alloc and retire are already gated off by the caller during a flush.
module rrs_ptr_ctrl #(
    parameter int N = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc,
    input  logic                   retire,
    input  logic                   flush,
    input  logic [$clog2(N)-1:0]   flush_tag,
    output logic [$clog2(N)-1:0]   head,
    output logic [$clog2(N)-1:0]   tail,
    output logic                   full,
    output logic                   empty
);
    localparam int IW = $clog2(N);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] cnt;
    logic [IW-1:0] flush_age;

    // Distance of the flushed slot from the oldest slot.
    always_comb flush_age = flush_tag - tail;

    // Advance the pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
        end else if (flush) begin
            head <= flush_tag + 1'b1;
            cnt  <= CW'(flush_age) + CW'(1);
        end else begin
            head <= head + IW'(alloc);
            tail <= tail + IW'(retire);
            cnt  <= cnt + CW'(alloc) - CW'(retire);
        end
    end

    // Occupancy flags.
    always_comb begin
        full  = (cnt == CW'(N));
        empty = (cnt == '0);
    end

    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !alloc);
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !retire);
endmodule

// File: rtl/rrs_src_lookup.sv
`timescale 1ns/1ps
// Associative rename lookup for one source operand.
// Matches active slots whose destination equals the source register and whose
// newest-writer bit is set. Skips a slot that commits in this cycle.
// Reports the producer's lock state, with a same-cycle update bypass.
// Assumes at most one newest writer per register.
module rrs_src_lookup #(
    parameter int N  = 8,
    parameter int RW = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N-1:0]                  live,
    input  logic [N-1:0]                  newest,
    input  logic [N-1:0]                  done,
    input  logic [N-1:0][RW-1:0]          dst,
    input  logic [RW-1:0]                 src,
    input  logic                          ret_fire,
    input  logic [$clog2(N)-1:0]          ret_slot,
    input  logic                          upd_valid,
    input  logic [$clog2(N)-1:0]          upd_tag,
    output logic                          hit,
    output logic [$clog2(N)-1:0]          id,
    output logic                          lock
);
    localparam int IW = $clog2(N);

    logic [N-1:0] match;

    // Compare the source against every slot's destination field.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            match[i] = live[i] && newest[i] && (dst[i] == src)
                       && !(ret_fire && (ret_slot == IW'(i)));
        end
    end

    // Encode the match and derive the lock state.
    always_comb begin
        id = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) id = id | IW'(i);
        end
        hit  = |match;
        lock = hit && !done[id] && !(upd_valid && (upd_tag == id));
    end

    p_single_writer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/rrs_flush_mask.sv
`timescale 1ns/1ps
// Flush support: finds the slots younger than flush_tag.
// For the slots that survive, recomputes which one is the newest writer of
// each destination register.
// Age is measured from the oldest slot (tail). Assumes flush_tag is active.
module rrs_flush_mask #(
    parameter int N  = 8,
    parameter int RW = 3
) (
    input  logic [N-1:0]          live,
    input  logic [N-1:0][RW-1:0]  dst,
    input  logic [$clog2(N)-1:0]  tail,
    input  logic [$clog2(N)-1:0]  flush_tag,
    output logic [N-1:0]          kill,
    output logic [N-1:0]          newest_fix
);
    localparam int IW = $clog2(N);

    logic [N-1:0][IW-1:0] age;
    logic [IW-1:0]        cut_age;
    logic [N-1:0]         keep;

    // Age of each slot and the set of slots kept.
    always_comb begin
        cut_age = flush_tag - tail;
        for (int i = 0; i < N; i++) begin
            age[i]  = IW'(i) - tail;
            kill[i] = live[i] && (age[i] > cut_age);
            keep[i] = live[i] && !kill[i];
        end
    end

    // A kept slot is newest unless a younger kept slot writes the same register.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            newest_fix[i] = keep[i];
            for (int j = 0; j < N; j++) begin
                if (keep[j] && (age[j] > age[i]) && (dst[j] == dst[i]))
                    newest_fix[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rrs_shelf.sv
`timescale 1ns/1ps
// Unified rename / reorder / reservation shelf.
// A circular array of N slots, one per instruction in flight, with the slot
// index serving as the tag.
// Handles one issue, update, dispatch and commit per cycle.
// Commits go out to an external architectural register file.
// Assumes updates, dispatches and flushes name active slots.
module rrs_shelf #(
    parameter int N    = 8,
    parameter int NREG = 8,
    parameter int DW   = 16,
    parameter int PW   = 16,
    localparam int IW  = $clog2(N),
    localparam int RW  = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    iss_valid,
    input  logic [RW-1:0]           iss_dst,
    input  logic [RW-1:0]           iss_src1,
    input  logic [RW-1:0]           iss_src2,
    input  logic [rrs_pkg::FU_W-1:0] iss_fu,
    input  logic [PW-1:0]           iss_pc,
    output logic [IW-1:0]           iss_tag,
    output logic                    iss_s1_hit,
    output logic [IW-1:0]           iss_s1_id,
    output logic                    iss_s1_lock,
    output logic                    iss_s2_hit,
    output logic [IW-1:0]           iss_s2_id,
    output logic                    iss_s2_lock,
    input  logic                    upd_valid,
    input  logic [IW-1:0]           upd_tag,
    input  logic [DW-1:0]           upd_data,
    input  logic                    disp_valid,
    input  logic [IW-1:0]           disp_tag,
    output logic [rrs_pkg::FU_W-1:0] disp_fu,
    output logic [PW-1:0]           disp_pc,
    output logic [RW-1:0]           disp_s1_reg,
    output logic [IW-1:0]           disp_s1_id,
    output logic                    disp_s1_hit,
    output logic [RW-1:0]           disp_s2_reg,
    output logic [IW-1:0]           disp_s2_id,
    output logic                    disp_s2_hit,
    output logic [N-1:0]            ready_vec,
    output logic                    ret_valid,
    output logic [RW-1:0]           ret_dst,
    output logic [DW-1:0]           ret_data,
    output logic [PW-1:0]           ret_pc,
    input  logic                    flush_valid,
    input  logic [IW-1:0]           flush_tag,
    output logic                    full,
    output logic                    empty
);
    import rrs_pkg::*;

    // Slot state.
    logic [N-1:0]            live, newest, disp, done;
    logic [N-1:0]            lk1, lk2, hv1, hv2;
    logic [N-1:0][RW-1:0]    rd, rn1, rn2;
    logic [N-1:0][IW-1:0]    id1, id2;
    logic [N-1:0][DW-1:0]    data;
    logic [N-1:0][PW-1:0]    pcs;
    fu_kind_e                fu [N];

    logic [IW-1:0]           head, tail;
    logic                    iss_fire, ret_fire;
    logic [N-1:0]            kill, newest_fix;
    logic [1:0][RW-1:0]      src;
    logic [1:0]              s_hit, s_lock;
    logic [1:0][IW-1:0]      s_id;

    // Accept issue and commit only outside a flush.
    always_comb begin
        iss_fire = iss_valid && !full && !flush_valid;
        ret_fire = live[tail] && done[tail] && !flush_valid;
    end

    rrs_ptr_ctrl #(.N(N)) u_ptr (
        .clk(clk), .rst_n(rst_n), .alloc(iss_fire), .retire(ret_fire),
        .flush(flush_valid), .flush_tag(flush_tag),
        .head(head), .tail(tail), .full(full), .empty(empty)
    );

    rrs_flush_mask #(.N(N), .RW(RW)) u_flush (
        .live(live), .dst(rd), .tail(tail), .flush_tag(flush_tag),
        .kill(kill), .newest_fix(newest_fix)
    );

    // Pack the two issue sources for the lookup array.
    always_comb begin
        src[0] = iss_src1;
        src[1] = iss_src2;
    end

    for (genvar s = 0; s < 2; s++) begin : g_lookup
        rrs_src_lookup #(.N(N), .RW(RW)) u_lk (
            .clk(clk), .rst_n(rst_n), .live(live), .newest(newest),
            .done(done), .dst(rd), .src(src[s]), .ret_fire(ret_fire),
            .ret_slot(tail), .upd_valid(upd_valid), .upd_tag(upd_tag),
            .hit(s_hit[s]), .id(s_id[s]), .lock(s_lock[s])
        );
    end

    // Issue-side outputs.
    always_comb begin
        iss_tag     = head;
        iss_s1_hit  = s_hit[0];
        iss_s1_id   = s_id[0];
        iss_s1_lock = s_lock[0];
        iss_s2_hit  = s_hit[1];
        iss_s2_id   = s_id[1];
        iss_s2_lock = s_lock[1];
    end

    // Slot state update: flush, commit, issue, wakeup, dispatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0; newest <= '0; disp <= '0; done <= '0;
            lk1 <= '0; lk2 <= '0; hv1 <= '0; hv2 <= '0;
            rd <= '0; rn1 <= '0; rn2 <= '0; id1 <= '0; id2 <= '0;
            data <= '0; pcs <= '0;
            for (int i = 0; i < N; i++) fu[i] <= FU_INT;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (flush_valid) begin
                    live[i]   <= live[i] && !kill[i];
                    newest[i] <= newest_fix[i];
                end else begin
                    if (ret_fire && (tail == IW'(i))) begin
                        live[i]   <= 1'b0;
                        newest[i] <= 1'b0;
                    end
                    if (iss_fire && live[i] && (rd[i] == iss_dst))
                        newest[i] <= 1'b0;
                end
                if (upd_valid && (upd_tag == IW'(i))) begin
                    data[i] <= upd_data;
                    done[i] <= 1'b1;
                end
                if (upd_valid && hv1[i] && (id1[i] == upd_tag)) lk1[i] <= 1'b0;
                if (upd_valid && hv2[i] && (id2[i] == upd_tag)) lk2[i] <= 1'b0;
                if (disp_valid && (disp_tag == IW'(i))) disp[i] <= 1'b1;
                if (iss_fire && (head == IW'(i))) begin
                    live[i]   <= 1'b1;
                    newest[i] <= 1'b1;
                    disp[i]   <= 1'b0;
                    done[i]   <= 1'b0;
                    rd[i]     <= iss_dst;
                    rn1[i]    <= iss_src1;
                    rn2[i]    <= iss_src2;
                    hv1[i]    <= s_hit[0];
                    hv2[i]    <= s_hit[1];
                    id1[i]    <= s_id[0];
                    id2[i]    <= s_id[1];
                    lk1[i]    <= s_lock[0];
                    lk2[i]    <= s_lock[1];
                    pcs[i]    <= iss_pc;
                    fu[i]     <= fu_kind_e'(iss_fu);
                end
            end
        end
    end

    // Readiness, dispatch read port and commit port.
    always_comb begin
        ready_vec   = live & ~lk1 & ~lk2 & ~disp & ~done;
        disp_fu     = fu[disp_tag];
        disp_pc     = pcs[disp_tag];
        disp_s1_reg = rn1[disp_tag];
        disp_s1_id  = id1[disp_tag];
        disp_s1_hit = hv1[disp_tag];
        disp_s2_reg = rn2[disp_tag];
        disp_s2_id  = id2[disp_tag];
        disp_s2_hit = hv2[disp_tag];
        ret_valid   = ret_fire;
        ret_dst     = rd[tail];
        ret_data    = data[tail];
        ret_pc      = pcs[tail];
    end

    p_alloc_slot_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire |-> !live[head]);
    p_upd_target_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> live[upd_tag]);
    p_exec_after_upd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !flush_valid) |=> done[$past(upd_tag)]);
    p_empty_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (live == '0));
    p_flush_target_live_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> live[flush_tag]);
endmodule

// File: tb/tb_rrs_shelf.sv
`timescale 1ns/1ps
module tb_rrs_shelf;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [2:0]  iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic [1:0]  iss_fu = '0;
    logic [15:0] iss_pc = '0;
    logic [2:0]  iss_tag, iss_s1_id, iss_s2_id;
    logic        iss_s1_hit, iss_s1_lock, iss_s2_hit, iss_s2_lock;
    logic        upd_valid = 1'b0;
    logic [2:0]  upd_tag = '0;
    logic [15:0] upd_data = '0;
    logic        disp_valid = 1'b0;
    logic [2:0]  disp_tag = '0;
    logic [1:0]  disp_fu;
    logic [15:0] disp_pc;
    logic [2:0]  disp_s1_reg, disp_s1_id, disp_s2_reg, disp_s2_id;
    logic        disp_s1_hit, disp_s2_hit;
    logic [7:0]  ready_vec;
    logic        ret_valid;
    logic [2:0]  ret_dst;
    logic [15:0] ret_data, ret_pc;
    logic        flush_valid = 1'b0;
    logic [2:0]  flush_tag = '0;
    logic        full, empty;

    always #4 clk = ~clk;

    rrs_shelf dut (.*);

    typedef struct {
        logic [2:0]  dst;
        logic [15:0] data;
        logic [15:0] pc;
    } exp_t;
    exp_t sbq[$];

    int nchk = 0;
    int nfail = 0;

    function automatic logic [15:0] pc_of(input int k);
        return 16'h0100 + 16'(4 * k);
    endfunction
    function automatic logic [15:0] data_of(input int k);
        return 16'hA000 + 16'(k);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: issue one instruction, check rename outputs, queue its commit.
    task automatic issue(input int k, input logic [2:0] dst, s1, s2,
                         input logic [2:0] etag,
                         input bit h1, input logic [2:0] i1, input bit l1,
                         input bit h2, input logic [2:0] i2, input bit l2,
                         input bit with_upd, input logic [2:0] utag, input int uk);
        exp_t e;
        @(negedge clk);
        iss_valid = 1'b1; iss_dst = dst; iss_src1 = s1; iss_src2 = s2;
        iss_pc = pc_of(k); iss_fu = 2'(k);
        if (with_upd) begin
            upd_valid = 1'b1; upd_tag = utag; upd_data = data_of(uk);
        end
        #1;
        chk("R2", "issue tag", 32'(iss_tag), 32'(etag));
        chk("R3", "src1 hit", 32'(iss_s1_hit), 32'(h1));
        chk("R3", "src2 hit", 32'(iss_s2_hit), 32'(h2));
        if (h1) chk("R3", "src1 id", 32'(iss_s1_id), 32'(i1));
        if (h2) chk("R3", "src2 id", 32'(iss_s2_id), 32'(i2));
        chk("R4", "src1 lock", 32'(iss_s1_lock), 32'(l1));
        chk("R4", "src2 lock", 32'(iss_s2_lock), 32'(l2));
        e.dst = dst; e.data = data_of(k); e.pc = pc_of(k);
        sbq.push_back(e);
        @(posedge clk);
        #1;
        iss_valid = 1'b0; upd_valid = 1'b0;
    endtask

    task automatic update(input logic [2:0] tag, input int k);
        @(negedge clk);
        upd_valid = 1'b1; upd_tag = tag; upd_data = data_of(k);
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    // Monitor: every commit must match the oldest expected instruction.
    always @(negedge clk) begin
        if (rst_n && ret_valid) begin
            if (sbq.size() == 0) begin
                chk("R8", "unexpected commit pc", 32'(ret_pc), 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk("R8", "commit dst", 32'(ret_dst), 32'(e.dst));
                chk("R8", "commit data", 32'(ret_data), 32'(e.data));
                chk("R8", "commit pc", 32'(ret_pc), 32'(e.pc));
            end
        end
    end

    initial begin
        #(200000 * 8);
        nfail++;
        $display("FAIL R12 watchdog expired");
        $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
        $finish;
    end

    initial begin
        // R1 reset state
        wait_cycles(3);
        @(negedge clk);
        chk("R1", "empty in reset", 32'(empty), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "empty", 32'(empty), 32'd1);
        chk("R1", "full", 32'(full), 32'd0);
        chk("R1", "ret_valid", 32'(ret_valid), 32'd0);
        chk("R1", "ready_vec", 32'(ready_vec), 32'd0);

        // A..D: rename chain; R5 newest writer of r1 moves from slot 0 to 2
        issue(0, 3'd1, 3'd2, 3'd3, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        issue(1, 3'd4, 3'd1, 3'd1, 3'd1, 1, 0, 1, 1, 0, 1, 0, 0, 0);
        issue(2, 3'd1, 3'd5, 3'd1, 3'd2, 0, 0, 0, 1, 0, 1, 0, 0, 0);
        issue(3, 3'd6, 3'd1, 3'd7, 3'd3, 1, 2, 1, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R6", "ready only A", 32'(ready_vec), 32'h01);
        chk("R1", "not empty", 32'(empty), 32'd0);

        // R7 dispatch readout and dispatched flag
        @(negedge clk);
        disp_tag = 3'd1; #1;
        chk("R7", "disp pc", 32'(disp_pc), 32'(pc_of(1)));
        chk("R7", "disp src1 reg", 32'(disp_s1_reg), 32'd1);
        chk("R7", "disp src1 id", 32'(disp_s1_id), 32'd0);
        chk("R7", "disp src2 hit", 32'(disp_s2_hit), 32'd1);
        disp_tag = 3'd0; disp_valid = 1'b1; #1;
        chk("R7", "disp fu", 32'(disp_fu), 32'd0);
        @(posedge clk); #1; disp_valid = 1'b0;
        @(negedge clk);
        chk("R7", "ready after dispatch", 32'(ready_vec), 32'h00);

        // R6 wakeup of B and C by A's result
        update(3'd0, 0);
        @(negedge clk);
        chk("R6", "ready B,C", 32'(ready_vec), 32'h06);
        // R8 C finishes before B: no commit while B is oldest
        update(3'd2, 2);
        @(negedge clk);
        chk("R8", "hold commit for B", 32'(ret_valid), 32'd0);
        chk("R6", "ready B,D", 32'(ready_vec), 32'h0A);
        update(3'd1, 1);
        wait_cycles(3);

        // R9 r1 writer C committed: lookup falls through
        issue(4, 3'd2, 3'd1, 3'd0, 3'd4, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R10 same-cycle update of D while F reads r6
        issue(5, 3'd5, 3'd6, 3'd7, 3'd5, 1, 3, 0, 0, 0, 0, 1, 3'd3, 3);
        @(negedge clk);
        chk("R10", "ready E,F", 32'(ready_vec), 32'h30);
        wait_cycles(2);

        // R11 flush at G: H and I discarded, newest bits rebuilt
        issue(6, 3'd3, 3'd0, 3'd0, 3'd6, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        issue(7, 3'd3, 3'd3, 3'd0, 3'd7, 1, 6, 1, 0, 0, 0, 0, 0, 0);
        issue(8, 3'd2, 3'd0, 3'd0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        void'(sbq.pop_back());
        void'(sbq.pop_back());
        @(negedge clk);
        flush_valid = 1'b1; flush_tag = 3'd6;
        @(posedge clk); #1; flush_valid = 1'b0;
        issue(9, 3'd4, 3'd3, 3'd2, 3'd7, 1, 6, 1, 1, 4, 1, 0, 0, 0);

        // R12 fill to full, then a rejected issue
        issue(10, 3'd0, 3'd0, 3'd0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        issue(11, 3'd0, 3'd0, 3'd0, 3'd1, 1, 0, 1, 1, 0, 1, 0, 0, 0);
        issue(12, 3'd7, 3'd0, 3'd0, 3'd2, 1, 1, 1, 1, 1, 1, 0, 0, 0);
        issue(13, 3'd6, 3'd7, 3'd0, 3'd3, 1, 2, 1, 1, 1, 1, 0, 0, 0);
        @(negedge clk);
        chk("R12", "full", 32'(full), 32'd1);
        iss_valid = 1'b1; iss_dst = 3'd5; iss_src1 = 3'd0; iss_src2 = 3'd0;
        iss_pc = pc_of(14);
        @(posedge clk); #1; iss_valid = 1'b0;
        @(negedge clk);
        chk("R12", "still full after reject", 32'(full), 32'd1);

        // Drain in program order
        update(3'd4, 4);
        update(3'd5, 5);
        update(3'd6, 6);
        update(3'd7, 9);
        update(3'd0, 10);
        update(3'd1, 11);
        update(3'd2, 12);
        update(3'd3, 13);
        wait_cycles(12);
        @(negedge clk);
        chk("R12", "empty after drain", 32'(empty), 32'd1);
        chk("R8", "all commits seen", 32'(sbq.size()), 32'd0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule